// File: doc/BRIEF.md
# Character Row Pixel Fetch Unit

This block turns a stream of character cells into a stream of 8-bit palette indices for a text-mode tile display. Each cell arrives as a character address and a 3-bit raster row from a CRT timing generator. The block reads a code byte and an attribute byte from video RAM. It joins the low attribute nibble above the code byte to form a 12-bit tile number, and from that number and the raster row it forms a graphics ROM byte address.

Each tile row is stored as two bitplane bytes, one in each half of the graphics ROM. The block reads both bytes and scatters their bits into four 4-bit pixel colours. It then emits four palette indices per cell, and each index carries the attribute high nibble as its colour bank. Both memories are synchronous and return data one cycle after the read.

The cell input and the pixel output are valid/ready streams. Back-pressure on the output holds the current pixel. It also stops new cells from being accepted once the block holds as many cells as its queue depth. A display-enable input blanks the output and pauses it.

Top module: `char_pixel_fetch`

## Requirements
- R1: In the cycle a cell is accepted (`cell_valid && cell_ready`), `vram_rd_en` is high, `vram_code_addr` equals the character address plus 1, and `vram_attr_addr` equals the character address plus 0x1001. Both sums are taken modulo 2^13.
- R2: In the cycle after a cell is accepted, `rom_rd_en` is high. In that cycle `rom_lo_addr` is {attribute[3:0], code[7:0], row[2:0]} (15 bits, zero-extended), and `rom_hi_addr` equals `rom_lo_addr` + 0x8000.
- R3: The plane word W is {byte read at `rom_hi_addr`, byte read at `rom_lo_addr`}. For pixel n of a cell (n = 0..3), the colour in index bits 3:0 is {W[n+4], W[n], W[n+12], W[n+8]}, listed from bit 3 down to bit 0.
- R4: Index bits 7:4 of every pixel of a cell equal bits 7:4 of that cell's attribute byte.
- R5: Each accepted cell produces exactly four output pixels, in the order n = 0,1,2,3. Cells come out in the order they were accepted, and no pixel appears without an accepted cell.
- R6: A ROM read follows every video RAM read in the next cycle. With the block empty and `de` and `pix_ready` high, pixel 0 of a cell accepted at clock edge k is valid after edge k+2. A back-to-back cell stream produces one pixel every clock with no gaps.
- R7: While `pix_valid` is high and `pix_ready` is low, the next cycle keeps `pix_valid` high and `pix_index` unchanged, unless `de` is low.
- R8: While `de` is low, `pix_valid` is low and `pix_index` is 0. No pixel is lost, and output resumes with the held pixel.
- R9: The block holds at most DEPTH (default 2) cells, counting in-flight fetches and queued cells. `cell_ready` is low while it holds DEPTH cells.
- R10: During reset, `pix_valid`, `vram_rd_en` and `rom_rd_en` are low, `pix_index` is 0, and `cell_ready` is high.

Back-pressure rules: a cell is taken on a clock edge where `cell_valid` and `cell_ready` are both high. A pixel is consumed on an edge where `pix_valid` and `pix_ready` are both high. `cell_ready` depends only on registered state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| de | input | 1 | Display enable; low blanks and pauses the output |
| cell_valid | input | 1 | Cell request valid |
| cell_ready | output | 1 | Block can take a cell |
| cell_addr | input | 12 | Character address from the CRT controller |
| cell_row | input | 3 | Raster row within the character |
| vram_rd_en | output | 1 | Video RAM read strobe |
| vram_code_addr | output | 13 | Video RAM address of the code byte |
| vram_attr_addr | output | 13 | Video RAM address of the attribute byte |
| vram_code_data | input | 8 | Code byte, one cycle after the read |
| vram_attr_data | input | 8 | Attribute byte, one cycle after the read |
| rom_rd_en | output | 1 | Graphics ROM read strobe |
| rom_lo_addr | output | 16 | ROM address of the low plane byte |
| rom_hi_addr | output | 16 | ROM address of the high plane byte |
| rom_lo_data | input | 8 | Low plane byte, one cycle after the read |
| rom_hi_data | input | 8 | High plane byte, one cycle after the read |
| pix_valid | output | 1 | Output pixel valid |
| pix_ready | input | 1 | Downstream takes the pixel |
| pix_index | output | 8 | Palette index: bank in bits 7:4, colour in bits 3:0 |

## Verification
On every cycle, the assertions check the local stream rules. A video RAM read is followed by a ROM read, and the two addresses of each read pair keep their fixed distance. A stalled pixel stays put, blanking holds while display enable is low, and the occupancy never goes past four pixels per queue entry. What only the bench scenarios can show is the data itself. Those scenarios cover the tile-number assembly, the bit scatter into each pixel, the colour bank, the pixel order across cells, the first-pixel latency, and the gap-free streaming under sustained input. The bench also shows that no pixel is lost across random stalls and blanking.

// File: rtl/cpf_pkg.sv
package cpf_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int WORD_W = 2 * BYTE_W;

  // One fetched tile row: colour bank plus both bitplanes.
  typedef struct packed {
    logic [NIB_W-1:0]  pal;
    logic [WORD_W-1:0] word;
  } cell_word_t;
endpackage

// File: rtl/cpf_addr_stage.sv
module cpf_addr_stage
  import cpf_pkg::*;
#(
  parameter int          CA_W      = 12,
  parameter int          ROW_W     = 3,
  parameter int          VR_AW     = 13,
  parameter int unsigned ATTR_BASE = 'h1000,
  parameter int          ROM_AW    = 16,
  parameter int unsigned HI_OFFSET = 'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [CA_W-1:0]   cell_addr,
  input  logic [ROW_W-1:0]  cell_row,
  output logic              vram_rd_en,
  output logic [VR_AW-1:0]  vram_code_addr,
  output logic [VR_AW-1:0]  vram_attr_addr,
  input  logic [BYTE_W-1:0] vram_code_data,
  input  logic [BYTE_W-1:0] vram_attr_data,
  output logic              rom_rd_en,
  output logic [ROM_AW-1:0] rom_lo_addr,
  output logic [ROM_AW-1:0] rom_hi_addr,
  output logic              s1_v,
  output logic              s2_v,
  output logic [NIB_W-1:0]  s2_pal
);
  localparam int TILE_W = NIB_W + BYTE_W;
  localparam int LO_W   = TILE_W + ROW_W;

  logic [ROW_W-1:0] s1_row;
  logic [LO_W-1:0]  lo_raw;

  // Stage 0: video RAM addresses straight from the accepted cell.
  assign vram_rd_en     = accept;
  assign vram_code_addr = VR_AW'(cell_addr) + VR_AW'(1);
  assign vram_attr_addr = vram_code_addr + VR_AW'(ATTR_BASE);

  // Stage 1: code and attribute bytes arrive; build the ROM row address.
  assign lo_raw      = {vram_attr_data[NIB_W-1:0], vram_code_data, s1_row};
  assign rom_rd_en   = s1_v;
  assign rom_lo_addr = ROM_AW'(lo_raw);
  assign rom_hi_addr = rom_lo_addr + ROM_AW'(HI_OFFSET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s1_row <= '0;
      s2_v   <= 1'b0;
      s2_pal <= '0;
    end else begin
      s1_v <= accept;
      s2_v <= s1_v;
      if (accept) s1_row <= cell_row;
      if (s1_v)   s2_pal <= vram_attr_data[BYTE_W-1:NIB_W];
    end
  end
endmodule

// File: rtl/cpf_cell_queue.sv
module cpf_cell_queue
  import cpf_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  cell_word_t       push_data,
  input  logic             pop,
  output cell_word_t       head,
  output logic             head_v,
  output logic [CNT_W-1:0] count
);
  cell_word_t       mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign head   = mem[rp];
  assign head_v = (count != '0);
endmodule

// File: rtl/cpf_pixel_serializer.sv
module cpf_pixel_serializer
  import cpf_pkg::*;
#(
  parameter int PIX_PER_CELL = 4,
  localparam int CNT_W = $clog2(PIX_PER_CELL),
  localparam int IDX_W = 2 * NIB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             de,
  input  logic             head_v,
  input  cell_word_t       head,
  input  logic             pix_ready,
  output logic             pix_valid,
  output logic [IDX_W-1:0] pix_index,
  output logic             pop
);
  logic [NIB_W-1:0] colour [PIX_PER_CELL];
  logic [CNT_W-1:0] pix_n;
  logic             fire, last;

  // Bit scatter: each pixel takes one bit from each nibble of the plane word.
  for (genvar g = 0; g < PIX_PER_CELL; g++) begin : g_scatter
    assign colour[g] = {head.word[g + NIB_W], head.word[g],
                        head.word[g + 3*NIB_W], head.word[g + 2*NIB_W]};
  end

  assign pix_valid = de && head_v;
  assign pix_index = pix_valid ? {head.pal, colour[pix_n]} : '0;
  assign fire      = pix_valid && pix_ready;
  assign last      = (pix_n == CNT_W'(PIX_PER_CELL - 1));
  assign pop       = fire && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pix_n <= '0;
    else if (fire) pix_n <= last ? '0 : pix_n + CNT_W'(1);
  end
endmodule

// File: rtl/char_pixel_fetch.sv
module char_pixel_fetch
  import cpf_pkg::*;
#(
  parameter int          CA_W      = 12,
  parameter int          ROW_W     = 3,
  parameter int          VR_AW     = 13,
  parameter int unsigned ATTR_BASE = 'h1000,
  parameter int          ROM_AW    = 16,
  parameter int unsigned HI_OFFSET = 'h8000,
  parameter int          DEPTH     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              de,
  input  logic              cell_valid,
  output logic              cell_ready,
  input  logic [CA_W-1:0]   cell_addr,
  input  logic [ROW_W-1:0]  cell_row,
  output logic              vram_rd_en,
  output logic [VR_AW-1:0]  vram_code_addr,
  output logic [VR_AW-1:0]  vram_attr_addr,
  input  logic [7:0]        vram_code_data,
  input  logic [7:0]        vram_attr_data,
  output logic              rom_rd_en,
  output logic [ROM_AW-1:0] rom_lo_addr,
  output logic [ROM_AW-1:0] rom_hi_addr,
  input  logic [7:0]        rom_lo_data,
  input  logic [7:0]        rom_hi_data,
  output logic              pix_valid,
  input  logic              pix_ready,
  output logic [7:0]        pix_index
);
  localparam int PIX_PER_CELL = 4;
  localparam int QC_W  = $clog2(DEPTH + 1);
  localparam int OCC_W = $clog2(DEPTH + 3);

  logic             accept, s1_v, s2_v, pop, head_v;
  logic [NIB_W-1:0] s2_pal;
  logic [QC_W-1:0]  q_count;
  logic [OCC_W-1:0] occupancy;
  cell_word_t       push_data, head;

  // Cells in flight plus queued cells bound the acceptance.
  assign occupancy  = OCC_W'(q_count) + OCC_W'(s1_v) + OCC_W'(s2_v);
  assign cell_ready = (occupancy < OCC_W'(DEPTH));
  assign accept     = cell_valid && cell_ready;

  cpf_addr_stage #(
    .CA_W(CA_W), .ROW_W(ROW_W), .VR_AW(VR_AW), .ATTR_BASE(ATTR_BASE),
    .ROM_AW(ROM_AW), .HI_OFFSET(HI_OFFSET)
  ) addr_i (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .cell_addr(cell_addr), .cell_row(cell_row),
    .vram_rd_en(vram_rd_en), .vram_code_addr(vram_code_addr),
    .vram_attr_addr(vram_attr_addr), .vram_code_data(vram_code_data),
    .vram_attr_data(vram_attr_data), .rom_rd_en(rom_rd_en),
    .rom_lo_addr(rom_lo_addr), .rom_hi_addr(rom_hi_addr),
    .s1_v(s1_v), .s2_v(s2_v), .s2_pal(s2_pal)
  );

  // Stage 2: both plane bytes arrive and enter the queue.
  assign push_data.pal  = s2_pal;
  assign push_data.word = {rom_hi_data, rom_lo_data};

  cpf_cell_queue #(.DEPTH(DEPTH)) queue_i (
    .clk(clk), .rst_n(rst_n), .push(s2_v), .push_data(push_data),
    .pop(pop), .head(head), .head_v(head_v), .count(q_count)
  );

  cpf_pixel_serializer #(.PIX_PER_CELL(PIX_PER_CELL)) ser_i (
    .clk(clk), .rst_n(rst_n), .de(de), .head_v(head_v), .head(head),
    .pix_ready(pix_ready), .pix_valid(pix_valid), .pix_index(pix_index),
    .pop(pop)
  );
endmodule

// File: rtl/cpf_checker.sv
module cpf_checker #(
  parameter int          VR_AW     = 13,
  parameter int unsigned ATTR_BASE = 'h1000,
  parameter int          ROM_AW    = 16,
  parameter int unsigned HI_OFFSET = 'h8000,
  parameter int          DEPTH     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              de,
  input logic              cell_valid,
  input logic              cell_ready,
  input logic              vram_rd_en,
  input logic [VR_AW-1:0]  vram_code_addr,
  input logic [VR_AW-1:0]  vram_attr_addr,
  input logic              rom_rd_en,
  input logic [ROM_AW-1:0] rom_lo_addr,
  input logic [ROM_AW-1:0] rom_hi_addr,
  input logic              pix_valid,
  input logic              pix_ready,
  input logic [7:0]        pix_index
);
  logic [7:0] owed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owed <= '0;
    else owed <= owed + ((cell_valid && cell_ready) ? 8'd4 : 8'd0)
                      - ((pix_valid && pix_ready) ? 8'd1 : 8'd0);
  end

  // R1
  vram_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_valid && cell_ready) |->
      (vram_rd_en && (VR_AW'(vram_attr_addr - vram_code_addr) == VR_AW'(ATTR_BASE))));

  // R2
  rom_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd_en |-> (ROM_AW'(rom_hi_addr - rom_lo_addr) == ROM_AW'(HI_OFFSET)));

  // R6
  rom_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vram_rd_en |=> rom_rd_en);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> (!de || (pix_valid && $stable(pix_index))));

  // R8
  blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> (!pix_valid && pix_index == 8'd0));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= 8'(4 * DEPTH));

  // R5
  pix_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (owed != 8'd0));
endmodule

bind char_pixel_fetch cpf_checker #(
  .VR_AW(VR_AW), .ATTR_BASE(ATTR_BASE), .ROM_AW(ROM_AW),
  .HI_OFFSET(HI_OFFSET), .DEPTH(DEPTH)
) chk_i (
  .clk(clk), .rst_n(rst_n), .de(de), .cell_valid(cell_valid),
  .cell_ready(cell_ready), .vram_rd_en(vram_rd_en),
  .vram_code_addr(vram_code_addr), .vram_attr_addr(vram_attr_addr),
  .rom_rd_en(rom_rd_en), .rom_lo_addr(rom_lo_addr), .rom_hi_addr(rom_hi_addr),
  .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_index(pix_index)
);

// File: tb/char_pixel_fetch_tb_top.sv
`timescale 1ns/1ps
module char_pixel_fetch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        de = 1'b1;
  logic        cell_valid = 1'b0;
  logic        cell_ready;
  logic [11:0] cell_addr = '0;
  logic [2:0]  cell_row = '0;
  logic        vram_rd_en, rom_rd_en, pix_valid;
  logic [12:0] vram_code_addr, vram_attr_addr;
  logic [7:0]  vram_code_data, vram_attr_data, rom_lo_data, rom_hi_data;
  logic [15:0] rom_lo_addr, rom_hi_addr;
  logic        pix_ready = 1'b1;
  logic [7:0]  pix_index;

  int   n_checks = 0;
  int   n_errors = 0;
  bit   all_done = 0;
  bit   measure = 0;
  bit   started = 0;
  int   gaps = 0;
  bit   prev_hold = 0;
  logic [7:0] prev_idx = '0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  char_pixel_fetch dut_i (
    .clk(clk), .rst_n(rst_n), .de(de), .cell_valid(cell_valid),
    .cell_ready(cell_ready), .cell_addr(cell_addr), .cell_row(cell_row),
    .vram_rd_en(vram_rd_en), .vram_code_addr(vram_code_addr),
    .vram_attr_addr(vram_attr_addr), .vram_code_data(vram_code_data),
    .vram_attr_data(vram_attr_data), .rom_rd_en(rom_rd_en),
    .rom_lo_addr(rom_lo_addr), .rom_hi_addr(rom_hi_addr),
    .rom_lo_data(rom_lo_data), .rom_hi_data(rom_hi_data),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_index(pix_index)
  );

  function automatic logic [7:0] vram_fn(input logic [12:0] a);
    return 8'((a * 13'd97) ^ (a >> 4) ^ 13'h0A5);
  endfunction

  function automatic logic [7:0] rom_fn(input logic [15:0] a);
    return 8'((a * 16'd173) ^ (a >> 7) ^ 16'h003C);
  endfunction

  // Synchronous memory models, one-cycle read latency.
  always @(posedge clk) begin
    if (vram_rd_en) begin
      vram_code_data <= vram_fn(vram_code_addr);
      vram_attr_data <= vram_fn(vram_attr_addr);
    end
    if (rom_rd_en) begin
      rom_lo_data <= rom_fn(rom_lo_addr);
      rom_hi_data <= rom_fn(rom_hi_addr);
    end
  end

  function automatic logic [15:0] exp_lo(input logic [11:0] a, input logic [2:0] r);
    logic [7:0] code, attr;
    code = vram_fn(13'(a) + 13'd1);
    attr = vram_fn(13'(a) + 13'h1001);
    return {1'b0, attr[3:0], code, r};
  endfunction

  function automatic logic [7:0] exp_pix(input logic [11:0] a, input logic [2:0] r, input int n);
    logic [7:0]  attr;
    logic [15:0] lo, w;
    attr = vram_fn(13'(a) + 13'h1001);
    lo = exp_lo(a, r);
    w = {rom_fn(lo + 16'h8000), rom_fn(lo)};
    return {attr[7:4], w[n+4], w[n], w[n+12], w[n+8]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: inputs change 2 ns after a rising edge, so the falling edge sees settled values.
  always @(negedge clk) begin
    if (rst_n && !all_done) begin
      if (cell_valid && cell_ready)
        for (int n = 0; n < 4; n++) exp_q.push_back(exp_pix(cell_addr, cell_row, n));
      if (!de) chk(!pix_valid && pix_index == 8'd0, "R8 blank", {pix_valid, pix_index}, 0);
      if (prev_hold && de) chk(pix_valid && pix_index == prev_idx, "R7 hold", pix_index, prev_idx);
      if (measure && started && !pix_valid && exp_q.size() != 0) gaps++;
      if (pix_valid && pix_ready) begin
        started = 1;
        if (exp_q.size() == 0) chk(0, "R5 extra pixel", pix_index, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(pix_index == e, "R3 R4 R5 pixel", pix_index, e);
        end
      end
      prev_hold = pix_valid && !pix_ready;
      prev_idx = pix_index;
    end
  end

  task automatic send_cell(input logic [11:0] a, input logic [2:0] r);
    cell_valid = 1'b1;
    cell_addr = a;
    cell_row = r;
    do @(negedge clk); while (!cell_ready);
    @(posedge clk); #2;
    cell_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((exp_q.size() != 0 || pix_valid) && guard < 4000) begin
      @(negedge clk);
      guard++;
    end
    chk(exp_q.size() == 0, "R5 drain", exp_q.size(), 0);
    @(posedge clk); #2;
  endtask

  task automatic latency_case(input logic [11:0] a, input logic [2:0] r, input logic [12:0] ec, input logic [12:0] ea);
    logic [15:0] lo;
    lo = exp_lo(a, r);
    @(posedge clk); #2;
    cell_valid = 1'b1; cell_addr = a; cell_row = r;
    #1;
    chk(vram_rd_en && vram_code_addr == ec && vram_attr_addr == ea, "R1 vram addr",
        {vram_code_addr, vram_attr_addr}, {ec, ea});
    @(posedge clk); #2;
    cell_valid = 1'b0;
    @(negedge clk);
    chk(rom_rd_en && rom_lo_addr == lo && rom_hi_addr == lo + 16'h8000, "R2 rom addr",
        {rom_lo_addr, rom_hi_addr}, {lo, lo + 16'h8000});
    chk(!pix_valid, "R6 latency early", pix_valid, 0);
    @(negedge clk);
    chk(!pix_valid, "R6 latency early", pix_valid, 0);
    @(negedge clk);
    chk(pix_valid, "R6 latency first pixel", pix_valid, 1);
    drain();
  endtask

  initial begin
    #200000000;
    if (!all_done) begin
      all_done = 1;
      n_checks++; n_errors++;
      $display("FAIL R5 watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    bit done;
    logic [7:0] lfsr;
    int acc;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!pix_valid && pix_index == 8'd0 && cell_ready && !vram_rd_en && !rom_rd_en,
        "R10 reset", {pix_valid, cell_ready, vram_rd_en, rom_rd_en, pix_index}, 12'h400);
    @(posedge clk); #2;
    rst_n = 1'b1;
    repeat (2) @(posedge clk); #2;

    // R1 R2 R6: directed latency, including the address wrap corner
    latency_case(12'hFFF, 3'd7, 13'h1000, 13'h0000);
    latency_case(12'h123, 3'd2, 13'h0124, 13'h1124);

    // R6: back-to-back stream, no gaps
    measure = 1; started = 0; gaps = 0;
    for (int i = 0; i < 256; i++) send_cell(12'(i * 37), 3'(i));
    drain();
    measure = 0;
    chk(gaps == 0, "R6 gapless stream", gaps, 0);

    // R9: stalled output, queue fills to DEPTH
    pix_ready = 1'b0;
    cell_valid = 1'b1; cell_addr = 12'h055; cell_row = 3'd4;
    acc = 0;
    repeat (20) begin
      @(negedge clk);
      if (cell_valid && cell_ready) acc++;
    end
    @(posedge clk); #2;
    cell_valid = 1'b0;
    #1;
    chk(acc == 2, "R9 accepted under stall", acc, 2);
    chk(!cell_ready, "R9 ready low when full", cell_ready, 0);
    chk(pix_valid, "R7 valid held under stall", pix_valid, 1);
    @(posedge clk); #2;
    pix_ready = 1'b1;
    drain();

    // R7 R8: random stalls and blanking during a stream
    done = 0;
    lfsr = 8'hA7;
    fork
      begin
        for (int i = 0; i < 256; i++) send_cell(12'(i * 101 + 7), 3'(i >> 2));
        done = 1;
      end
      begin
        while (!done) begin
          @(posedge clk); #2;
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          pix_ready = lfsr[0] | lfsr[2];
          de = lfsr[1] | lfsr[4] | lfsr[6];
        end
      end
    join
    @(posedge clk); #2;
    pix_ready = 1'b1; de = 1'b1;
    drain();

    // R8: long blank with a cell pending, then resume
    de = 1'b0;
    send_cell(12'h3A0, 3'd5);
    repeat (6) @(negedge clk);
    chk(!pix_valid && pix_index == 8'd0, "R8 long blank", pix_index, 0);
    @(posedge clk); #2;
    de = 1'b1;
    drain();

    all_done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule